// File: doc/BRIEF.md
# Width-Selectable Synchronous FIFO with Programmable Threshold Flags

This block is a single-clock first-in first-out buffer. Its storage array has a fixed number of bits. At master reset the array is set up either as a narrow buffer of 9-bit words, or as a wide buffer of 18-bit words that holds half as many entries. The same core therefore serves both bus widths without a second build. Reads and writes share one clock, and both may happen on the same edge.

Besides the full, empty and half-full indications, the block drives two threshold flags. These warn when the buffer is nearly drained or nearly filled. Their distances come from one of two preset defaults, picked at master reset. They can be changed later, either over a one-bit serial path or as words taken from the write data bus. Read timing is also picked at master reset:

- **Registered read:** a word appears only after an explicit read.
- **Fall-through:** the head word is presented on its own.

A partial reset empties the buffer but keeps the programmed thresholds and modes. A retransmit input rewinds the read side so that stored data can be read out again.

Top module: `wsel_fifo`

## Requirements
- R1: `width_sel` is sampled while `mrs` is high.
  - 0 gives 9-bit words and a depth of 2^AW. Only `wdata[8:0]` is stored, and `rdata[17:9]` reads 0.
  - 1 gives 18-bit words and a depth of 2^(AW-1).
- R2: A master reset (`mrs` high on a clock edge) empties the buffer and clears `rdata` to 0. It also captures `width_sel`, `fwft_sel` and `ofs_sel`, and loads both threshold distances with their default.
- R3: A partial reset (`prs` high on an edge, `mrs` low) empties the buffer and clears `rdata`. Both threshold distances and both mode selections stay as they were.
- R4: Registered-read mode (`fwft_sel`=0 at reset):
  - `rd_block` is high exactly when the buffer holds no word.
  - A read accepted on an edge places the oldest word on `rdata` after that edge, and `rdata` holds it until the next accepted read.
- R5: Fall-through mode (`fwft_sel`=1 at reset):
  - A word written into an empty buffer appears on `rdata` one edge after the write edge, with `rd_block` low, and no read is needed.
  - An accepted read moves `rdata` on to the next word at that same edge.
  - `rd_block` rises only when no word is left.
- R6: `wr_block` is high when the occupancy equals the configured depth.
  - A write while `wr_block` is high is ignored.
  - A read while no word is available is ignored: the occupancy, the flags and `rdata` are unchanged.
- R7: `half_full` is high when the occupancy is strictly greater than half the configured depth.
- R8: Threshold flags:
  - `almost_empty` is high when the occupancy is at or below the empty distance.
  - `almost_full` is high when the free space is at or below the full distance.
  - At master reset both distances take DEF_SHORT when `ofs_sel`=0, or DEF_LONG when `ofs_sel`=1.
- R9: Parallel loading of the distances:
  - An edge with `load` and `wr_en` both high copies `wdata[AW:0]` into a distance register and writes no data word.
  - The first such edge after any reset loads the empty distance. Later edges alternate between the full and the empty distance.
- R10: Serial loading of the distances:
  - Each edge with `ser_en` high shifts `ser_in` into a 2*(AW+1)-bit chain.
  - After 2*(AW+1) shifts, the first AW+1 bits, least significant first, form the empty distance, and the next AW+1 bits form the full distance.
- R11: An edge with `rt` high moves the read side back to the first stored location. The words written since the last reset, fewer than the depth, are then read again in their original order. Any read or write on that same edge is ignored.
- R12: An edge that accepts both a read and a write leaves the occupancy and all occupancy flags unchanged, and keeps the data in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrs | input | 1 | Master reset, synchronous, active high |
| prs | input | 1 | Partial reset, synchronous, active high |
| width_sel | input | 1 | Word width choice sampled at master reset (1 = 18-bit) |
| fwft_sel | input | 1 | Read timing choice sampled at master reset (1 = fall-through) |
| ofs_sel | input | 1 | Default threshold choice sampled at master reset |
| wr_en | input | 1 | Write request |
| load | input | 1 | With `wr_en`, routes `wdata` to the threshold registers |
| wdata | input | 18 | Write data |
| rd_en | input | 1 | Read request |
| ser_en | input | 1 | Serial threshold shift enable |
| ser_in | input | 1 | Serial threshold data bit |
| rt | input | 1 | Retransmit: rewind the read side |
| rdata | output | 18 | Output data register |
| rd_block | output | 1 | No word available to read |
| wr_block | output | 1 | Buffer full, writes refused |
| half_full | output | 1 | Occupancy above half the depth |
| almost_empty | output | 1 | Occupancy at or below the empty distance |
| almost_full | output | 1 | Free space at or below the full distance |

## Verification
The bench builds the block with AW=6, DEF_SHORT=3 and DEF_LONG=7. This gives a 64-entry narrow buffer and a 32-entry wide one. With depths this small, each buffer is filled to the top and drained within a few hundred cycles. At every occupancy step the bench checks all flag thresholds, both defaults, and values that were loaded in parallel or serially. The short depth also brings refused writes at full, retransmit replay and partial-reset retention within a few short directed scenarios, in both width modes and both read timings.

// File: rtl/wsf_pkg.sv
package wsf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } tmode_e;

    localparam int HALF_W = 9;
    localparam int WORD_W = 2 * HALF_W;

endpackage

// File: rtl/wsf_store.sv
module wsf_store
    import wsf_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wide,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int RW   = AW - 1;
    localparam int ROWS = 2 ** RW;

    logic [RW-1:0]     wrow;
    logic [RW-1:0]     rrow;
    logic [HALF_W-1:0] rd_half [2];

    // narrow mode: address bit 0 picks the half, the rest picks the row
    assign wrow = wide ? waddr[RW-1:0] : waddr[AW-1:1];
    assign rrow = wide ? raddr[RW-1:0] : raddr[AW-1:1];

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic [HALF_W-1:0] mem [ROWS];
        logic              hwe;
        logic [HALF_W-1:0] hdat;

        assign hwe  = we && (wide || (waddr[0] == 1'(g)));
        assign hdat = wide ? wdata[HALF_W*g +: HALF_W] : wdata[HALF_W-1:0];

        always_ff @(posedge clk) begin
            if (hwe) begin
                mem[wrow] <= hdat;
            end
        end

        assign rd_half[g] = mem[rrow];
    end

    always_comb begin
        if (wide) begin
            rdata = {rd_half[1], rd_half[0]};
        end else begin
            rdata = {{HALF_W{1'b0}}, (raddr[0] ? rd_half[1] : rd_half[0])};
        end
    end

endmodule

// File: rtl/wsf_ofs_regs.sv
module wsf_ofs_regs #(
    parameter int OW        = 11,
    parameter int DEF_SHORT = 7,
    parameter int DEF_LONG  = 127
) (
    input  logic          clk,
    input  logic          mrs,
    input  logic          prs,
    input  logic          def_sel,
    input  logic          par_we,
    input  logic [OW-1:0] par_val,
    input  logic          ser_en,
    input  logic          ser_in,
    output logic [OW-1:0] ofs_e,
    output logic [OW-1:0] ofs_f
);

    localparam logic [OW-1:0] SHORT_V = OW'(DEF_SHORT);
    localparam logic [OW-1:0] LONG_V  = OW'(DEF_LONG);

    typedef struct packed {
        logic [2*OW-1:0] pair;   // {full distance, empty distance}
        logic            sel;    // next parallel target: 0 empty, 1 full
    } ofs_t;

    ofs_t ofs_d, ofs_q;

    always_comb begin
        ofs_d = ofs_q;
        if (mrs) begin
            ofs_d.pair = def_sel ? {LONG_V, LONG_V} : {SHORT_V, SHORT_V};
            ofs_d.sel  = 1'b0;
        end else if (prs) begin
            ofs_d.sel = 1'b0;
        end else if (ser_en) begin
            ofs_d.pair = {ser_in, ofs_q.pair[2*OW-1:1]};
        end else if (par_we) begin
            if (ofs_q.sel) begin
                ofs_d.pair[2*OW-1:OW] = par_val;
            end else begin
                ofs_d.pair[OW-1:0] = par_val;
            end
            ofs_d.sel = ~ofs_q.sel;
        end
    end

    always_ff @(posedge clk) begin
        ofs_q <= ofs_d;
    end

    assign ofs_e = ofs_q.pair[OW-1:0];
    assign ofs_f = ofs_q.pair[2*OW-1:OW];

endmodule

// File: rtl/wsf_flags.sv
module wsf_flags #(
    parameter int AW = 10
) (
    input  logic [AW:0] occ,
    input  logic [AW:0] depth,
    input  logic [AW:0] ofs_e,
    input  logic [AW:0] ofs_f,
    output logic        full,
    output logic        half,
    output logic        almost_e,
    output logic        almost_f
);

    logic [AW:0] space;

    always_comb begin
        space    = depth - occ;
        full     = (occ == depth);
        half     = (occ > (depth >> 1));
        almost_e = (occ <= ofs_e);
        almost_f = (space <= ofs_f);
    end

endmodule

// File: rtl/wsel_fifo.sv
module wsel_fifo
    import wsf_pkg::*;
#(
    parameter int AW        = 10,
    parameter int DEF_SHORT = 7,
    parameter int DEF_LONG  = 127
) (
    input  logic        clk,
    input  logic        mrs,
    input  logic        prs,
    input  logic        width_sel,
    input  logic        fwft_sel,
    input  logic        ofs_sel,
    input  logic        wr_en,
    input  logic        load,
    input  logic [17:0] wdata,
    input  logic        rd_en,
    input  logic        ser_en,
    input  logic        ser_in,
    input  logic        rt,
    output logic [17:0] rdata,
    output logic        rd_block,
    output logic        wr_block,
    output logic        half_full,
    output logic        almost_empty,
    output logic        almost_full
);

    localparam int          OW      = AW + 1;
    localparam logic [AW:0] DEPTH_N = OW'(2 ** AW);
    localparam logic [AW:0] DEPTH_W = OW'(2 ** (AW - 1));

    typedef struct packed {
        logic              wide;
        tmode_e            tm;
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [AW:0]       cnt;     // words held in the array
        logic              ovalid;  // fall-through output register loaded
        logic [WORD_W-1:0] dout;
    } core_t;

    core_t st_d, st_q;

    logic [AW:0]       depth_cfg;
    logic [AW:0]       occ;
    logic [AW:0]       stored;
    logic [AW-1:0]     ofs_e;
    logic [AW-1:0]     ofs_e_lo;
    logic [OW-1:0]     ofs_e_w;
    logic [OW-1:0]     ofs_f_w;
    logic              full_w;
    logic              wr_acc;
    logic              rd_std;
    logic              consume;
    logic              pop;
    logic              mem_we;
    logic              wide_mode;
    logic [WORD_W-1:0] mem_rd;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic w);
        logic [AW-1:0] n;
        n = p + 1'b1;
        if (w) begin
            n[AW-1] = 1'b0;
        end
        return n;
    endfunction

    assign depth_cfg = st_q.wide ? DEPTH_W : DEPTH_N;
    assign occ       = (st_q.tm == MODE_FWFT) ? (st_q.cnt + OW'(st_q.ovalid)) : st_q.cnt;
    assign stored    = st_q.cnt;
    assign wide_mode = st_q.wide;
    assign ofs_e_lo  = ofs_e_w[AW-1:0];
    assign ofs_e     = ofs_e_lo;

    wsf_ofs_regs #(
        .OW        (OW),
        .DEF_SHORT (DEF_SHORT),
        .DEF_LONG  (DEF_LONG)
    ) u_ofs (
        .clk     (clk),
        .mrs     (mrs),
        .prs     (prs),
        .def_sel (ofs_sel),
        .par_we  (load && wr_en && !mrs && !prs),
        .par_val (wdata[OW-1:0]),
        .ser_en  (ser_en),
        .ser_in  (ser_in),
        .ofs_e   (ofs_e_w),
        .ofs_f   (ofs_f_w)
    );

    wsf_flags #(
        .AW (AW)
    ) u_flags (
        .occ      (occ),
        .depth    (depth_cfg),
        .ofs_e    (ofs_e_w),
        .ofs_f    (ofs_f_w),
        .full     (full_w),
        .half     (half_full),
        .almost_e (almost_empty),
        .almost_f (almost_full)
    );

    wsf_store #(
        .AW (AW)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .wide  (st_q.wide),
        .waddr (st_q.wptr),
        .wdata (wdata),
        .raddr (st_q.rptr),
        .rdata (mem_rd)
    );

    always_comb begin
        wr_acc  = wr_en && !load && !full_w;
        rd_std  = rd_en && (st_q.cnt != '0);
        consume = rd_en && st_q.ovalid;
        if (st_q.tm == MODE_FWFT) begin
            pop = (st_q.cnt != '0) && (!st_q.ovalid || consume);
        end else begin
            pop = rd_std;
        end
        mem_we = wr_acc && !mrs && !prs && !rt;

        st_d = st_q;
        if (mrs) begin
            st_d.wide   = width_sel;
            st_d.tm     = tmode_e'(fwft_sel);
            st_d.wptr   = '0;
            st_d.rptr   = '0;
            st_d.cnt    = '0;
            st_d.ovalid = 1'b0;
            st_d.dout   = '0;
        end else if (prs) begin
            st_d.wptr   = '0;
            st_d.rptr   = '0;
            st_d.cnt    = '0;
            st_d.ovalid = 1'b0;
            st_d.dout   = '0;
        end else if (rt) begin
            st_d.rptr   = '0;
            st_d.cnt    = {1'b0, st_q.wptr};
            st_d.ovalid = 1'b0;
        end else begin
            if (wr_acc) begin
                st_d.wptr = step(st_q.wptr, st_q.wide);
            end
            if (pop) begin
                st_d.rptr = step(st_q.rptr, st_q.wide);
                st_d.dout = mem_rd;
            end
            st_d.cnt = st_q.cnt + OW'(wr_acc) - OW'(pop);
            if (st_q.tm == MODE_FWFT) begin
                if (pop) begin
                    st_d.ovalid = 1'b1;
                end else if (consume) begin
                    st_d.ovalid = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata    = st_q.dout;
    assign rd_block = (st_q.tm == MODE_FWFT) ? !st_q.ovalid : (st_q.cnt == '0);
    assign wr_block = full_w;

endmodule

// File: rtl/wsel_fifo_chk.sv
module wsel_fifo_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          mrs,
    input logic          prs,
    input logic          wr_en,
    input logic          load,
    input logic          rd_en,
    input logic          rt,
    input logic [17:0]   rdata,
    input logic          rd_block,
    input logic          wr_block,
    input logic          half_full,
    input logic          almost_empty,
    input logic          almost_full,
    input logic [AW:0]   stored,
    input logic          wide_mode,
    input logic [AW-1:0] ofs_e,
    input logic [AW:0]   ofs_f
);

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (mrs)
        wr_block && wr_en && !rd_en && !rt && !prs |=> wr_block);

    // R6
    empty_read_ignored_chk: assert property (@(posedge clk) disable iff (mrs)
        rd_block && (stored == '0) && rd_en && !wr_en && !rt && !prs
        |=> rd_block && $stable(rdata));

    // R7
    full_implies_upper_chk: assert property (@(posedge clk) disable iff (mrs)
        wr_block |-> half_full && almost_full);

    // R3
    prs_clear_chk: assert property (@(posedge clk) disable iff (mrs)
        prs |=> rd_block && !wr_block && almost_empty);

    // R3
    prs_keeps_ofs_chk: assert property (@(posedge clk) disable iff (mrs)
        prs |=> $stable(ofs_e) && $stable(ofs_f));

    // R12
    same_edge_rw_chk: assert property (@(posedge clk) disable iff (mrs)
        !rd_block && !wr_block && rd_en && wr_en && !load && !rt && !prs
        |=> $stable(half_full) && $stable(almost_empty) && $stable(almost_full) && !wr_block);

    // R1
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (mrs)
        !wide_mode |-> rdata[17:9] == 9'd0);

endmodule

bind wsel_fifo wsel_fifo_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .mrs          (mrs),
    .prs          (prs),
    .wr_en        (wr_en),
    .load         (load),
    .rd_en        (rd_en),
    .rt           (rt),
    .rdata        (rdata),
    .rd_block     (rd_block),
    .wr_block     (wr_block),
    .half_full    (half_full),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .stored       (stored),
    .wide_mode    (wide_mode),
    .ofs_e        (ofs_e),
    .ofs_f        (ofs_f_w)
);

// File: tb/test_wsel_fifo.sv
module test_wsel_fifo;

    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int DS    = 3;
    localparam int DL    = 7;
    localparam int D_N   = 64;
    localparam int D_W   = 32;

    logic        clk = 1'b0;
    logic        mrs = 1'b1;
    logic        prs = 1'b0;
    logic        width_sel = 1'b0;
    logic        fwft_sel = 1'b0;
    logic        ofs_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        load = 1'b0;
    logic [17:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic        ser_en = 1'b0;
    logic        ser_in = 1'b0;
    logic        rt = 1'b0;
    logic [17:0] rdata;
    logic        rd_block, wr_block, half_full, almost_empty, almost_full;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P / 2) clk = ~clk;

    wsel_fifo #(.AW(AW), .DEF_SHORT(DS), .DEF_LONG(DL)) i_wsel_fifo (
        .clk(clk), .mrs(mrs), .prs(prs), .width_sel(width_sel), .fwft_sel(fwft_sel),
        .ofs_sel(ofs_sel), .wr_en(wr_en), .load(load), .wdata(wdata), .rd_en(rd_en),
        .ser_en(ser_en), .ser_in(ser_in), .rt(rt), .rdata(rdata), .rd_block(rd_block),
        .wr_block(wr_block), .half_full(half_full), .almost_empty(almost_empty),
        .almost_full(almost_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [17:0] dat(input int i);
        return 18'(i * 37 + 18'h2A5C3);
    endfunction

    function automatic logic [17:0] nar(input logic [17:0] d);
        return {9'd0, d[8:0]};
    endfunction

    task automatic do_mrs(input logic w, input logic f, input logic s);
        width_sel = w; fwft_sel = f; ofs_sel = s;
        mrs = 1'b1;
        tick();
        tick();
        mrs = 1'b0;
    endtask

    task automatic flags(input string tag, input int n, input int d, input int oe, input int of);
        chk({tag, " wr_block"},     32'(wr_block),     32'(n == d));
        chk({tag, " half_full"},    32'(half_full),    32'(n > d / 2));
        chk({tag, " almost_empty"}, 32'(almost_empty), 32'(n <= oe));
        chk({tag, " almost_full"},  32'(almost_full),  32'((d - n) <= of));
    endtask

    task automatic push(input logic [17:0] d);
        wr_en = 1'b1; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic fill(input string tag, input int n0, input int cnt, input int d,
                        input int oe, input int of);
        for (int i = 0; i < cnt; i++) begin
            push(dat(n0 + i));
            flags(tag, n0 + i + 1, d, oe, of);
        end
    endtask

    task automatic pop_std(input string tag, input logic [17:0] exp);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk(tag, 32'(rdata), 32'(exp));
    endtask

    task automatic t_reset();
        do_mrs(1'b0, 1'b0, 1'b0);
        chk("R2 reset rd_block", 32'(rd_block), 1);
        chk("R2 reset rdata", 32'(rdata), 0);
        flags("R2 reset", 0, D_N, DS, DS);
    endtask

    task automatic t_narrow_std();
        logic [17:0] last;
        do_mrs(1'b0, 1'b0, 1'b0);
        fill("R8 narrow fill", 0, D_N, D_N, DS, DS);
        push(18'h3FFFF);
        flags("R6 write at full", D_N, D_N, DS, DS);
        for (int i = 0; i < D_N; i++) begin
            pop_std("R1 R4 narrow data", nar(dat(i)));
        end
        chk("R4 drained rd_block", 32'(rd_block), 1);
        last = rdata;
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk("R6 read when empty rdata", 32'(rdata), 32'(last));
        chk("R6 read when empty rd_block", 32'(rd_block), 1);
        flags("R6 read when empty", 0, D_N, DS, DS);
    endtask

    task automatic t_wide_std();
        do_mrs(1'b1, 1'b0, 1'b1);
        flags("R8 wide long default", 0, D_W, DL, DL);
        fill("R1 R7 wide fill", 0, D_W, D_W, DL, DL);
        for (int i = 0; i < D_W; i++) begin
            pop_std("R1 wide data", dat(i));
        end
        chk("R1 wide drained", 32'(rd_block), 1);
    endtask

    task automatic t_fwft();
        do_mrs(1'b0, 1'b1, 1'b0);
        push(dat(0));
        chk("R5 first write not yet shown", 32'(rd_block), 1);
        tick();
        chk("R5 fall-through rd_block", 32'(rd_block), 0);
        chk("R5 fall-through data", 32'(rdata), 32'(nar(dat(0))));
        fill("R5 fwft fill", 1, D_N - 1, D_N, DS, DS);
        for (int i = 0; i < D_N; i++) begin
            chk("R5 fwft head", 32'(rdata), 32'(nar(dat(i))));
            rd_en = 1'b1;
            tick();
            rd_en = 1'b0;
        end
        chk("R5 fwft drained", 32'(rd_block), 1);
        do_mrs(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) push(dat(i + 70));
        tick();
        for (int i = 0; i < 3; i++) begin
            chk("R1 R5 wide fwft head", 32'(rdata), 32'(dat(i + 70)));
            rd_en = 1'b1;
            tick();
            rd_en = 1'b0;
        end
        chk("R5 wide fwft drained", 32'(rd_block), 1);
    endtask

    task automatic t_par_prs();
        do_mrs(1'b0, 1'b0, 1'b0);
        load = 1'b1; wr_en = 1'b1;
        wdata = 18'd10; tick();
        wdata = 18'd20; tick();
        load = 1'b0; wr_en = 1'b0;
        chk("R9 load stores no data", 32'(rd_block), 1);
        fill("R9 parallel offsets", 0, D_N, D_N, 10, 20);
        prs = 1'b1; tick(); prs = 1'b0;
        chk("R3 prs empties", 32'(rd_block), 1);
        flags("R3 prs flags", 0, D_N, 10, 20);
        fill("R3 offsets kept", 0, 40, D_N, 10, 20);
        pop_std("R3 narrow mode kept", nar(dat(0)));
    endtask

    task automatic t_serial();
        logic [13:0] bits;
        do_mrs(1'b0, 1'b0, 1'b1);
        bits = {7'd9, 7'd5};
        ser_en = 1'b1;
        for (int i = 0; i < 14; i++) begin
            ser_in = bits[i];
            tick();
        end
        ser_en = 1'b0;
        flags("R10 serial empty state", 0, D_N, 5, 9);
        fill("R10 serial offsets", 0, D_N, D_N, 5, 9);
    endtask

    task automatic t_rt();
        do_mrs(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) push(dat(i + 100));
        for (int i = 0; i < 3; i++) pop_std("R11 first pass", nar(dat(i + 100)));
        rt = 1'b1; tick(); rt = 1'b0;
        flags("R11 after rewind", 5, D_N, DS, DS);
        for (int i = 0; i < 5; i++) pop_std("R11 replay", nar(dat(i + 100)));
        chk("R11 replay drained", 32'(rd_block), 1);
    endtask

    task automatic t_simul();
        do_mrs(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) push(dat(i + 200));
        for (int i = 0; i < 6; i++) begin
            rd_en = 1'b1; wr_en = 1'b1; wdata = dat(i + 300);
            tick();
            rd_en = 1'b0; wr_en = 1'b0;
            chk("R12 same-edge data", 32'(rdata),
                32'(nar(i < 4 ? dat(i + 200) : dat(i - 4 + 300))));
            flags("R12 same-edge occupancy", 4, D_N, DS, DS);
        end
        for (int i = 2; i < 6; i++) pop_std("R12 tail order", nar(dat(i + 300)));
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_narrow_std();
        t_wide_std();
        t_fwft();
        t_par_prs();
        t_serial();
        t_rt();
        t_simul();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule